// File: doc/BRIEF.md
# Flash Sector Erase Status Poller

This block sits on the host side of a parallel NOR flash and runs one sector erase job on behalf of the system. A single request names a starting sector and a number of consecutive sectors. The block writes the first erase command. For each further sector, it reads the erase-window status bit, writes the next erase command, and reads that bit again to confirm the window was still open. It then polls the status byte until the progress bit stops toggling.

If the flash raises its internal time-limit bit while the operation still looks active, the block takes two confirming reads. A true failure causes a reset command write and an error result. A configurable poll ceiling guards against a flash that never settles. After either kind of error the block is idle again and takes new requests.

The flash port is a synchronous strobe interface. Read data is registered by the flash side and returns one cycle after the read strobe. Each command is reduced to a single write cycle.

Top module: `flash_erase_poller`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low, and no bus strobe is issued while `busy` is low.
- R2: A `req` seen while idle raises `busy` in the next cycle. It then writes erase code 0x30 to address `req_sector << OFS_W`. A `req_count` of zero is handled as one sector. Only codes 0x30 and 0xF0 are ever written.
- R3: Each further sector is written only after a status read with bit 3 low. Sectors advance by one. If that pre-write read shows bit 3 high, the write is skipped, the remaining sectors are dropped and `partial` is set.
- R4: After each further sector write, the block reads the status again. If bit 3 is high, `partial` is set and any sectors still pending are dropped.
- R5: Two consecutive poll reads with the same bit 6 end the job with a `done` pulse, `err_kind` 0 and no reset write.
- R6: A poll read with bit 5 high while bit 6 still toggles triggers two more reads. If bit 6 differs between those two reads, the block writes reset code 0xF0 to address 0. In the following cycle it pulses `error` with `err_kind` 1.
- R7: If the two confirming reads of R6 show the same bit 6, the job ends with `done`, `err_kind` 0 and no reset write.
- R8: After MAX_POLLS poll reads without completion or a bit-5 event, the block writes reset code 0xF0 and pulses `error` with `err_kind` 2.
- R9: `done` and `error` are single-cycle pulses and never occur together. `busy` stays high until the pulse and is low in the cycle after it. A new request is accepted after any result, including an error.
- R10: `req` is ignored while `busy` is high; it causes no extra erase write and no change of sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start an erase job (sampled while idle) |
| req_sector | input | SECT_W | First sector of the job |
| req_count | input | SECT_W+1 | Number of sectors (0 handled as 1) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: job finished normally |
| error | output | 1 | One-cycle pulse: job failed |
| err_kind | output | 2 | 0 none, 1 flash failure, 2 poll limit; valid with the pulse |
| partial | output | 1 | Some sector command may not have been accepted; valid with the pulse |
| bus_en | output | 1 | Bus cycle strobe |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | SECT_W+OFS_W | Bus address |
| bus_wdata | output | 8 | Command code |
| bus_rdata | input | 8 | Status byte, valid one cycle after a read strobe |

## Verification
The bench builds the block with SECT_W=4, OFS_W=4 and MAX_POLLS=24. The short poll ceiling makes the limit error reachable within a few hundred cycles, where the default would need a million reads. With 4-bit sectors, each erase address can be told apart in the flash model's write log. The flash model is scripted per job: when bit 3 closes, how many reads toggle bit 6, and when bit 5 rises. This brings into reach a pre-write window closure, a post-write window closure, a hard failure, and a failure flag that races with normal completion.

// File: rtl/fep_pkg.sv
// Shared constants and types for the flash erase poller.
// Assumes an 8-bit status byte with window, limit and toggle flags at fixed bits.
package fep_pkg;

    localparam logic [7:0] CMD_ERASE = 8'h30;
    localparam logic [7:0] CMD_RESET = 8'hF0;

    localparam int WIN_BIT = 3;   // erase window closed when 1
    localparam int LIM_BIT = 5;   // internal time limit exceeded
    localparam int TOG_BIT = 6;   // toggles while operation runs

    typedef enum logic [1:0] {
        RES_OK         = 2'd0,
        RES_FLASH_FAIL = 2'd1,
        RES_POLL_LIMIT = 2'd2
    } result_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_FIRST,
        S_PRE_RD,
        S_PRE_WT,
        S_WR_NEXT,
        S_POST_RD,
        S_POST_WT,
        S_POLL_RD,
        S_POLL_WT,
        S_CONF_RD,
        S_CONF_WT,
        S_RST_WR,
        S_REPORT
    } state_t;

endpackage

// File: rtl/fep_sector_walk.sv
// Tracks the sector currently addressed and how many sectors remain.
// Assumes step is only asserted while more is high.
module fep_sector_walk #(
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SECT_W-1:0] first,
    input  logic [SECT_W:0]   count,
    input  logic              step,
    input  logic              drop,
    output logic [SECT_W-1:0] cur_sector,
    output logic              more
);

    logic [SECT_W:0] remain;

    // Load job, advance to the next sector, or discard pending sectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sector <= '0;
            remain     <= '0;
        end else if (load) begin
            cur_sector <= first;
            remain     <= (count == '0) ? '0 : count - 1'b1;
        end else if (drop) begin
            remain <= '0;
        end else if (step) begin
            cur_sector <= cur_sector + 1'b1;
            remain     <= remain - 1'b1;
        end
    end

    assign more = (remain != '0);

    AST_STEP_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> more); // R3

endmodule

// File: rtl/fep_toggle_cmp.sv
// Remembers the toggle bit of the last sampled read and reports whether
// the current read repeats it. Cleared at job start and before confirmation.
module fep_toggle_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic bit_now,
    output logic have_prev,
    output logic same
);

    logic prev_bit;

    // Capture the toggle bit of a read, or forget the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
        end else if (clr) begin
            have_prev <= 1'b0;
        end else if (smp) begin
            have_prev <= 1'b1;
            prev_bit  <= bit_now;
        end
    end

    assign same = have_prev && (prev_bit == bit_now);

    AST_SAMPLE_ARMS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && !clr) |=> have_prev); // R5

endmodule

// File: rtl/fep_poll_limit.sv
// Counts poll reads that did not finish the job; flags the last allowed one.
module fep_poll_limit #(
    parameter int MAX_POLLS = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt;

    // Count unfinished poll reads since job start.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc && cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign at_last = (cnt == LAST);

    AST_POLLS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R8

endmodule

// File: rtl/flash_erase_poller.sv
// Host-side sector erase sequencer for a NOR flash.
// Issues the erase commands, checks the erase window flag around each added
// sector, polls the toggle bit to completion, and recovers from flash time-limit
// or poll-limit failures with a reset command. Assumes the flash returns read
// data one cycle after the read strobe.
module flash_erase_poller
    import fep_pkg::*;
#(
    parameter int SECT_W    = 4,
    parameter int OFS_W     = 12,
    parameter int MAX_POLLS = 1000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic [SECT_W-1:0]       req_sector,
    input  logic [SECT_W:0]         req_count,
    output logic                    busy,
    output logic                    done,
    output logic                    error,
    output logic [1:0]              err_kind,
    output logic                    partial,
    output logic                    bus_en,
    output logic                    bus_we,
    output logic [SECT_W+OFS_W-1:0] bus_addr,
    output logic [7:0]              bus_wdata,
    input  logic [7:0]              bus_rdata
);

    localparam int ADDR_W = SECT_W + OFS_W;

    state_t            state;
    result_t           result;
    logic [SECT_W-1:0] cur_sector;
    logic              more, have_prev, same, at_last;
    logic              walk_load, walk_step, walk_drop;
    logic              tog_clr, tog_smp, lim_inc;
    logic              win_closed, lim_flag;

    assign win_closed = bus_rdata[WIN_BIT];
    assign lim_flag   = bus_rdata[LIM_BIT];

    // Derive the one-cycle strobes for the helper blocks from state and status.
    always_comb begin
        walk_load = (state == S_IDLE) && req;
        walk_step = (state == S_PRE_WT) && !win_closed;
        walk_drop = ((state == S_PRE_WT) || (state == S_POST_WT)) && win_closed;
        tog_clr   = walk_load || ((state == S_POLL_WT) && !same && lim_flag);
        lim_inc   = (state == S_POLL_WT) && !same && !lim_flag;
        tog_smp   = lim_inc || ((state == S_CONF_WT) && !have_prev);
    end

    fep_sector_walk #(.SECT_W(SECT_W)) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (walk_load),
        .first      (req_sector),
        .count      (req_count),
        .step       (walk_step),
        .drop       (walk_drop),
        .cur_sector (cur_sector),
        .more       (more)
    );

    fep_toggle_cmp tog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tog_clr),
        .smp       (tog_smp),
        .bit_now   (bus_rdata[TOG_BIT]),
        .have_prev (have_prev),
        .same      (same)
    );

    fep_poll_limit #(.MAX_POLLS(MAX_POLLS)) lim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (walk_load),
        .inc     (lim_inc),
        .at_last (at_last)
    );

    // Sequence the job: commands, window checks, polling, recovery, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            result  <= RES_OK;
            partial <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req) begin
                    state   <= S_WR_FIRST;
                    result  <= RES_OK;
                    partial <= 1'b0;
                end
                S_WR_FIRST: state <= more ? S_PRE_RD : S_POLL_RD;
                S_PRE_RD:   state <= S_PRE_WT;
                S_PRE_WT: begin
                    if (win_closed) begin
                        partial <= 1'b1;
                        state   <= S_POLL_RD;
                    end else begin
                        state <= S_WR_NEXT;
                    end
                end
                S_WR_NEXT:  state <= S_POST_RD;
                S_POST_RD:  state <= S_POST_WT;
                S_POST_WT: begin
                    if (win_closed) begin
                        partial <= 1'b1;
                        state   <= S_POLL_RD;
                    end else begin
                        state <= more ? S_PRE_RD : S_POLL_RD;
                    end
                end
                S_POLL_RD:  state <= S_POLL_WT;
                S_POLL_WT: begin
                    if (same) begin
                        result <= RES_OK;
                        state  <= S_REPORT;
                    end else if (lim_flag) begin
                        state <= S_CONF_RD;
                    end else if (at_last) begin
                        result <= RES_POLL_LIMIT;
                        state  <= S_RST_WR;
                    end else begin
                        state <= S_POLL_RD;
                    end
                end
                S_CONF_RD:  state <= S_CONF_WT;
                S_CONF_WT: begin
                    if (!have_prev) begin
                        state <= S_CONF_RD;
                    end else if (same) begin
                        result <= RES_OK;
                        state  <= S_REPORT;
                    end else begin
                        result <= RES_FLASH_FAIL;
                        state  <= S_RST_WR;
                    end
                end
                S_RST_WR:   state <= S_REPORT;
                default:    state <= S_IDLE;
            endcase
        end
    end

    // Drive the flash strobes and address from the current state.
    always_comb begin
        bus_en    = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = CMD_ERASE;
        bus_addr  = {cur_sector, {OFS_W{1'b0}}};
        case (state)
            S_WR_FIRST, S_WR_NEXT: begin
                bus_en = 1'b1;
                bus_we = 1'b1;
            end
            S_PRE_RD, S_POST_RD, S_POLL_RD, S_CONF_RD: bus_en = 1'b1;
            S_RST_WR: begin
                bus_en    = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = CMD_RESET;
                bus_addr  = '0;
            end
            default: ;
        endcase
    end

    assign busy     = (state != S_IDLE);
    assign done     = (state == S_REPORT) && (result == RES_OK);
    assign error    = (state == S_REPORT) && (result != RES_OK);
    assign err_kind = result;

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_en); // R1
    AST_ONLY_KNOWN_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we) |-> (bus_wdata == CMD_ERASE || bus_wdata == CMD_RESET)); // R2
    AST_BUSY_UNTIL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !error) |=> busy); // R9
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> !(done || error || busy)); // R9
    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R9
    AST_ERROR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(bus_en && bus_we && bus_wdata == CMD_RESET)); // R6
    AST_DONE_WITHOUT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(bus_en && bus_we && bus_wdata == CMD_RESET)); // R5

endmodule

// File: tb/flash_erase_poller_tb_top.sv
// Scoreboard bench: the driver queues expected job results, a flash model
// logs bus writes and scripts status bytes, and a monitor compares each result.
module flash_erase_poller_tb_top;

    localparam int SECT_W    = 4;
    localparam int OFS_W     = 4;
    localparam int MAX_POLLS = 24;
    localparam int ADDR_W    = SECT_W + OFS_W;

    typedef struct {
        int kind;
        int part;
        int ewr;
        int rst;
        int first_a;
        int last_a;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [SECT_W-1:0] req_sector = '0;
    logic [SECT_W:0]   req_count = '0;
    logic              busy, done, error, partial, bus_en, bus_we;
    logic [1:0]        err_kind;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata = 8'hFF;

    int compared = 0;
    int mismatched = 0;
    exp_t expq[$];

    // scripted flash model state
    logic mdl_clear = 1'b0;
    int   sc_close = 100, sc_busy = 0, sc_fail = 0;
    int   ewr = 0, rd_cnt = 0, first_a = 0, last_a = 0;
    logic rst_seen = 1'b0, tog = 1'b0;
    logic erasing, dq3v, dq5v;

    always #2 clk = ~clk;

    flash_erase_poller #(.SECT_W(SECT_W), .OFS_W(OFS_W), .MAX_POLLS(MAX_POLLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_sector(req_sector), .req_count(req_count),
        .busy(busy), .done(done), .error(error), .err_kind(err_kind), .partial(partial),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    assign erasing = (ewr > 0) && !rst_seen && (rd_cnt < sc_busy);
    assign dq3v    = (ewr >= sc_close);
    assign dq5v    = (sc_fail != 0) && (rd_cnt >= sc_fail);

    // Flash model: log commands, answer reads one cycle later.
    always @(posedge clk) begin
        if (mdl_clear) begin
            ewr <= 0; rd_cnt <= 0; first_a <= 0; last_a <= 0;
            rst_seen <= 1'b0; tog <= 1'b0;
        end else if (bus_en) begin
            if (bus_we) begin
                if (bus_wdata == 8'h30) begin
                    if (ewr == 0) first_a <= int'(bus_addr);
                    last_a <= int'(bus_addr);
                    ewr <= ewr + 1;
                end else if (bus_wdata == 8'hF0 && bus_addr == '0) begin
                    rst_seen <= 1'b1;
                end
            end else begin
                rd_cnt <= rd_cnt + 1;
                if (erasing) begin
                    bus_rdata <= {1'b0, tog, dq5v, 1'b0, dq3v, 3'b000};
                    tog <= ~tog;
                end else begin
                    bus_rdata <= 8'hFF;
                end
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pop an expected item on each result pulse and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (done || error) begin
                if (expq.size() == 0) begin
                    check("R9", "unexpected result pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(e.tag, "result kind", error ? int'(err_kind) : 0, e.kind);
                    check(e.tag, "done vs error", int'(done), (e.kind == 0) ? 1 : 0);
                    check(e.tag, "partial flag", int'(partial), e.part);
                    check(e.tag, "erase writes", ewr, e.ewr);
                    check(e.tag, "reset written", int'(rst_seen), e.rst);
                    check(e.tag, "first erase addr", first_a, e.first_a);
                    check(e.tag, "last erase addr", last_a, e.last_a);
                end
                @(negedge clk);
                check("R9", "pulse width/busy after result", int'(done || error || busy), 0);
            end
        end
    end

    task automatic run_case(input string tag, input int sect, input int cnt, input int close_at,
                            input int busy_reads, input int fail_at, input bit poke,
                            input int ekind, input int epart, input int eewr, input int erst);
        exp_t e;
        int n;
        n = (cnt == 0) ? 1 : cnt;
        e.kind = ekind; e.part = epart; e.ewr = eewr; e.rst = erst;
        e.first_a = sect << OFS_W;
        e.last_a  = (sect + eewr - 1) << OFS_W;
        e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        sc_close = close_at; sc_busy = busy_reads; sc_fail = fail_at;
        req = 1'b1; req_sector = SECT_W'(sect); req_count = (SECT_W+1)'(cnt);
        mdl_clear = 1'b1;
        @(negedge clk);
        req = 1'b0; mdl_clear = 1'b0;
        check("R2", "busy after request", int'(busy), 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            req = 1'b1; req_sector = 4'hF; req_count = 5'd4;   // R10: must be ignored
            @(negedge clk);
            req = 1'b0;
        end
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        if (busy) check(tag, "job never finished", 1, 0);
        repeat (2) @(negedge clk);
        if (n < 0) $display("never");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        mismatched++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Driver: reset checks, then scripted jobs.
    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "error after reset", int'(error), 0);
        check("R1", "bus strobe after reset", int'(bus_en), 0);

        //       tag   sect cnt close busy  fail poke kind part ewr rst
        run_case("R5",  3,  1, 100,  12,    0, 0,   0,   0,   1,  0);
        run_case("R3",  5,  4, 100,  12,    0, 0,   0,   0,   4,  0);
        run_case("R4",  2,  3,   2,  12,    0, 0,   0,   1,   2,  0);
        run_case("R3",  9,  2,   1,  12,    0, 0,   0,   1,   1,  0);
        run_case("R6",  1,  1, 100, 10000,  6, 0,   1,   0,   1,  1);
        run_case("R9",  7,  1, 100,  12,    0, 0,   0,   0,   1,  0);
        run_case("R7",  4,  1, 100,   7,    6, 0,   0,   0,   1,  0);
        run_case("R8",  0,  1, 100, 10000,  0, 0,   2,   0,   1,  1);
        run_case("R10", 6,  2, 100,  12,    0, 1,   0,   0,   2,  0);
        run_case("R2", 11,  0, 100,  12,    0, 0,   0,   0,   1,  0);

        check("R9", "results outstanding", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule